// File: doc/BRIEF.md
# Serial Configuration Write Port with Staged Commit

This block receives configuration words for a frequency synthesizer over a three-wire write-only serial link: a serial clock, a serial data line and a load strobe. All three pins are brought into a fast system clock domain through synchronizers. The block then finds the serial clock and load strobe edges there. Each serial clock rising edge shifts one data bit into a 32-bit word, most significant bit first. A load strobe rising edge sends the finished word to one of six configuration registers. The low three bits of the word pick the register.

Some fields do not take effect when their own register is written. They wait in a staging copy until the next write to register 0. At that point they become active in the same system clock cycle as the new integer and fractional values. These fields are the modulus, phase, reference counter, reference doubler, reference halver and charge-pump level. The output divider select is staged in the same way, but only while a buffering enable bit in register 2 is set. When that bit is clear, the divider select takes effect at once. The rest of the synthesizer reads the active fields directly from the output ports.

Top module: `serial_cfg_port`

## Requirements
- R1: While rst_n is low, and after it is released before any write, every configuration output is zero.
- R2: Each rising edge of sclk shifts sdata into a 32-bit word, most significant bit first. Only the last 32 bits shifted before a load count.
- R3: A rising edge of sle copies the word into the register chosen by bits 2:0 (codes 0 to 5 select registers 0 to 5). Outputs do not change without such a load.
- R4: A load with code 6 or 7 changes no output.
- R5: A register 0 load puts bits 18:3 on int_word and bits 30:19 on frac_word straight away.
- R6: A register 1 load puts bit 27 on prescale_sel straight away. It stages bits 14:3 (modulus) and bits 26:15 (phase) without changing mod_word or phase_word.
- R7: A register 2 load puts bit 13 on div_buf_en straight away. It stages bits 12:9 (cp_level), 23:14 (rdiv_word), bit 24 (ref_half) and bit 25 (ref_dbl).
- R8: A register 0 load makes every staged value active in the same cycle as its own fields.
- R9: A register 4 load puts bits 31:3 on r4_word straight away. Its divider select, bits 22:20, reaches out_div at once when div_buf_en is 0. When div_buf_en is 1, it waits for the next register 0 load. A register 0 load always copies the last staged divider select to out_div.
- R10: A register 3 or register 5 load puts bits 31:3 of the word on r3_word or r5_word straight away.
- R11: Each pin passes through two synchronizer flops. An output changes on the third system clock edge that follows the first edge seeing sle high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk | input | 1 | Serial clock pin |
| sdata | input | 1 | Serial data pin |
| sle | input | 1 | Load strobe pin |
| int_word | output | 16 | Active integer divide value |
| frac_word | output | 12 | Active fractional numerator |
| prescale_sel | output | 1 | Prescaler select |
| mod_word | output | 12 | Active fractional modulus |
| phase_word | output | 12 | Active phase word |
| rdiv_word | output | 10 | Active reference counter value |
| ref_dbl | output | 1 | Active reference doubler enable |
| ref_half | output | 1 | Active reference halver enable |
| cp_level | output | 4 | Active charge-pump current code |
| div_buf_en | output | 1 | Divider select buffering enable |
| out_div | output | 3 | Active output divider select |
| r3_word | output | 29 | Register 3 contents, bits 31:3 |
| r4_word | output | 29 | Register 4 contents, bits 31:3 |
| r5_word | output | 29 | Register 5 contents, bits 31:3 |

## Verification
An edge on a pin takes effect three system clock edges after the pin is first sampled. That is two synchronizer stages plus the edge-detect stage. The reference model applies each sample it takes at a posedge only three edges later, so its outputs change in the same cycle as the design's. The model is compared at every falling edge. One directed test raises the strobe and looks at the outputs after the second edge, where they must still hold the old values, and after the third edge, where they must hold the new ones. Staged fields are checked again after the staging load but before the register 0 load that commits them.

// File: rtl/serial_cfg_port.sv
module serial_cfg_port #(
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        sclk,
  input  logic        sdata,
  input  logic        sle,
  output logic [15:0] int_word,
  output logic [11:0] frac_word,
  output logic        prescale_sel,
  output logic [11:0] mod_word,
  output logic [11:0] phase_word,
  output logic [9:0]  rdiv_word,
  output logic        ref_dbl,
  output logic        ref_half,
  output logic [3:0]  cp_level,
  output logic        div_buf_en,
  output logic [2:0]  out_div,
  output logic [28:0] r3_word,
  output logic [28:0] r4_word,
  output logic [28:0] r5_word
);
  localparam int TOP = SYNC_STAGES - 1;

  logic [TOP:0] ck_s, dt_s, le_s;
  logic         ck_d, le_d;
  logic [31:0]  shreg;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      ck_s <= '0; dt_s <= '0; le_s <= '0; ck_d <= 1'b0; le_d <= 1'b0;
    end else begin
      ck_s <= {ck_s[TOP-1:0], sclk};
      dt_s <= {dt_s[TOP-1:0], sdata};
      le_s <= {le_s[TOP-1:0], sle};
      ck_d <= ck_s[TOP];
      le_d <= le_s[TOP];
    end

  wire       shift_ev = ck_s[TOP] & ~ck_d;
  wire       load_ev  = le_s[TOP] & ~le_d;
  wire [2:0] code     = shreg[2:0];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) shreg <= '0;
    else if (shift_ev) shreg <= {shreg[30:0], dt_s[TOP]};

  logic [11:0] mod_stg, ph_stg;
  logic [9:0]  rdiv_stg;
  logic        dbl_stg, half_stg;
  logic [3:0]  cp_stg;
  logic [2:0]  div_stg;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      int_word <= '0; frac_word <= '0; prescale_sel <= 1'b0;
      mod_word <= '0; phase_word <= '0; rdiv_word <= '0;
      ref_dbl <= 1'b0; ref_half <= 1'b0; cp_level <= '0;
      div_buf_en <= 1'b0; out_div <= '0;
      r3_word <= '0; r4_word <= '0; r5_word <= '0;
      mod_stg <= '0; ph_stg <= '0; rdiv_stg <= '0;
      dbl_stg <= 1'b0; half_stg <= 1'b0; cp_stg <= '0; div_stg <= '0;
    end else if (load_ev) begin
      case (code)
        3'd0: begin
          int_word   <= shreg[18:3];
          frac_word  <= shreg[30:19];
          mod_word   <= mod_stg;
          phase_word <= ph_stg;
          rdiv_word  <= rdiv_stg;
          ref_dbl    <= dbl_stg;
          ref_half   <= half_stg;
          cp_level   <= cp_stg;
          out_div    <= div_stg;
        end
        3'd1: begin
          mod_stg      <= shreg[14:3];
          ph_stg       <= shreg[26:15];
          prescale_sel <= shreg[27];
        end
        3'd2: begin
          cp_stg     <= shreg[12:9];
          div_buf_en <= shreg[13];
          rdiv_stg   <= shreg[23:14];
          half_stg   <= shreg[24];
          dbl_stg    <= shreg[25];
        end
        3'd3: r3_word <= shreg[31:3];
        3'd4: begin
          r4_word <= shreg[31:3];
          div_stg <= shreg[22:20];
          if (!div_buf_en) out_div <= shreg[22:20];
        end
        3'd5: r5_word <= shreg[31:3];
        default: ;
      endcase
    end

  AST_QUIET_WITHOUT_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    !load_ev |=> $stable({int_word, frac_word, mod_word, out_div, r4_word})); // R3
  AST_HIGH_CODES_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (load_ev && code > 3'd5) |=> $stable({int_word, frac_word, prescale_sel, mod_word,
      phase_word, rdiv_word, cp_level, div_buf_en, out_div, r3_word, r4_word, r5_word})); // R4
  AST_STAGED_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (load_ev && code != 3'd0) |=> $stable({mod_word, phase_word, rdiv_word, ref_dbl, ref_half, cp_level})); // R6
  AST_COMMIT_ON_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (load_ev && code == 3'd0) |=> (mod_word == $past(mod_stg) && rdiv_word == $past(rdiv_stg)
      && out_div == $past(div_stg))); // R8
  AST_DIV_DIRECT: assert property (@(posedge clk) disable iff (!rst_n)
    (load_ev && code == 3'd4 && !div_buf_en) |=> out_div == $past(shreg[22:20])); // R9
  AST_DIV_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (load_ev && code == 3'd4 && div_buf_en) |=> $stable(out_div)); // R9
endmodule

// File: tb/sim_serial_cfg_port.sv
module sim_serial_cfg_port;
  logic clk = 1'b0, rst_n = 1'b0, sclk = 1'b0, sdata = 1'b0, sle = 1'b0;
  logic [15:0] int_word; logic [11:0] frac_word, mod_word, phase_word;
  logic prescale_sel, ref_dbl, ref_half, div_buf_en;
  logic [9:0] rdiv_word; logic [3:0] cp_level; logic [2:0] out_div;
  logic [28:0] r3_word, r4_word, r5_word;
  int tests = 0, fails = 0;
  bit done = 0;

  always #10 clk = ~clk;

  serial_cfg_port u0 (.clk, .rst_n, .sclk, .sdata, .sle, .int_word, .frac_word,
    .prescale_sel, .mod_word, .phase_word, .rdiv_word, .ref_dbl, .ref_half,
    .cp_level, .div_buf_en, .out_div, .r3_word, .r4_word, .r5_word);

  logic [2:0]  hist[$];
  logic [2:0]  nw, od;
  logic [31:0] m_sh, w0, w1n, w1a, w2n, w2a, w3, w4, w5;
  logic [2:0]  m_div, m_divstg;

  always @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      hist = '{3'b0, 3'b0, 3'b0};
      m_sh = 0; w0 = 0; w1n = 0; w1a = 0; w2n = 0; w2a = 0; w3 = 0; w4 = 0; w5 = 0;
      m_div = 0; m_divstg = 0;
    end else begin
      nw = hist[1]; od = hist[2];
      if (nw[0] && !od[0]) begin
        case (m_sh[2:0])
          3'd0: begin w0 = m_sh; w1a = w1n; w2a = w2n; m_div = m_divstg; end
          3'd1: w1n = m_sh;
          3'd2: w2n = m_sh;
          3'd3: w3 = m_sh;
          3'd4: begin w4 = m_sh; m_divstg = m_sh[22:20]; if (!w2n[13]) m_div = m_sh[22:20]; end
          3'd5: w5 = m_sh;
          default: ;
        endcase
      end
      if (nw[2] && !od[2]) m_sh = {m_sh[30:0], nw[1]};
      hist.push_front({sclk, sdata, sle});
      void'(hist.pop_back());
    end

  task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  always @(negedge clk) if (rst_n && !done) begin
    chk("R5", "int_word", 32'(int_word), 32'(w0[18:3]));
    chk("R5", "frac_word", 32'(frac_word), 32'(w0[30:19]));
    chk("R6", "prescale_sel", 32'(prescale_sel), 32'(w1n[27]));
    chk("R8", "mod_word", 32'(mod_word), 32'(w1a[14:3]));
    chk("R8", "phase_word", 32'(phase_word), 32'(w1a[26:15]));
    chk("R7", "rdiv_word", 32'(rdiv_word), 32'(w2a[23:14]));
    chk("R7", "ref_half", 32'(ref_half), 32'(w2a[24]));
    chk("R7", "ref_dbl", 32'(ref_dbl), 32'(w2a[25]));
    chk("R7", "cp_level", 32'(cp_level), 32'(w2a[12:9]));
    chk("R7", "div_buf_en", 32'(div_buf_en), 32'(w2n[13]));
    chk("R9", "out_div", 32'(out_div), 32'(m_div));
    chk("R10", "r3_word", 32'(r3_word), 32'(w3[31:3]));
    chk("R9", "r4_word", 32'(r4_word), 32'(w4[31:3]));
    chk("R10", "r5_word", 32'(r5_word), 32'(w5[31:3]));
  end

  task automatic shift_bits(logic [63:0] bits, int n);
    for (int i = n - 1; i >= 0; i--) begin
      @(negedge clk); sdata = bits[i];
      repeat (3) @(negedge clk); sclk = 1'b1;
      repeat (3) @(negedge clk); sclk = 1'b0;
    end
    repeat (3) @(negedge clk);
  endtask

  task automatic send(logic [31:0] w);
    shift_bits({32'd0, w}, 32);
    sle = 1'b1; repeat (3) @(negedge clk); sle = 1'b0; repeat (6) @(negedge clk);
  endtask

  function automatic logic [31:0] mk0(logic [15:0] iv, logic [11:0] fr);
    mk0 = {1'b0, fr, iv, 3'd0};
  endfunction
  function automatic logic [31:0] mk1(logic [11:0] md, logic [11:0] ph, logic p);
    mk1 = {4'd0, p, ph, md, 3'd1};
  endfunction
  function automatic logic [31:0] mk2(logic [3:0] cp, logic be, logic [9:0] rd, logic hf, logic db);
    mk2 = {6'd0, db, hf, rd, be, cp, 6'd0, 3'd2};
  endfunction
  function automatic logic [31:0] mk4(logic [2:0] dv, logic [15:0] other);
    mk4 = {9'd0, dv, 1'b0, other, 3'd4};
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1", "int_word in reset", 32'(int_word), 0);
    chk("R1", "out_div in reset", 32'(out_div), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1", "mod_word after reset", 32'(mod_word), 0);
    chk("R1", "r5_word after reset", 32'(r5_word), 0);

    send(mk0(16'd100, 12'd26));
    chk("R5", "int value", 32'(int_word), 100);
    chk("R5", "frac value", 32'(frac_word), 26);

    send(mk1(12'd125, 12'd1, 1'b1));
    chk("R6", "prescaler immediate", 32'(prescale_sel), 1);
    chk("R6", "modulus held", 32'(mod_word), 0);
    send(mk2(4'd7, 1'b0, 10'd5, 1'b1, 1'b0));
    chk("R7", "rdiv held", 32'(rdiv_word), 0);
    chk("R7", "cp held", 32'(cp_level), 0);
    send(mk0(16'd75, 12'd3));
    chk("R8", "modulus commit", 32'(mod_word), 125);
    chk("R8", "rdiv commit", 32'(rdiv_word), 5);
    chk("R8", "cp commit", 32'(cp_level), 7);
    chk("R8", "halver commit", 32'(ref_half), 1);

    send(mk4(3'd5, 16'h1234));
    chk("R9", "divider direct", 32'(out_div), 5);
    send(mk2(4'd7, 1'b1, 10'd5, 1'b1, 1'b0));
    send(mk4(3'd3, 16'h0));
    chk("R9", "divider held", 32'(out_div), 5);
    send(mk0(16'd80, 12'd0));
    chk("R9", "divider commit", 32'(out_div), 3);

    send({29'h0ABCDEF, 3'd3});
    chk("R10", "r3 load", 32'(r3_word), 32'h0ABCDEF);
    send({29'h1555AAA, 3'd5});
    chk("R10", "r5 load", 32'(r5_word), 32'h1555AAA);
    send({29'h1FFFFFF, 3'd6});
    send({29'h1FFFFFF, 3'd7});
    chk("R4", "code 6/7 r3 unchanged", 32'(r3_word), 32'h0ABCDEF);
    chk("R4", "code 6/7 int unchanged", 32'(int_word), 80);

    shift_bits({32'hFFFF_FFFF, mk0(16'h4321, 12'd9)}, 64);
    sle = 1'b1;
    @(posedge clk); @(posedge clk); @(negedge clk);
    chk("R11", "no change after two edges", 32'(int_word), 80);
    @(posedge clk); @(negedge clk);
    chk("R11", "change on third edge", 32'(int_word), 32'h4321);
    chk("R2", "only last 32 bits kept", 32'(frac_word), 9);
    repeat (3) @(negedge clk); sle = 1'b0; repeat (6) @(negedge clk);

    send(mk1(12'd7, 12'd2, 1'b0));
    send(mk0(16'd90, 12'd1));
    chk("R3", "phase commit", 32'(phase_word), 2);
    repeat (20) @(negedge clk);
    chk("R3", "idle keeps int", 32'(int_word), 90);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule